// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block works out the memory address for a 32-bit load or store, and the value the base register should take afterwards. Each request carries a base register value, a current program-counter value, two offset sources and a set of decoded mode fields. The offset is either a 12-bit signed immediate or a register value sent through a logical barrel shifter. The offset is then added to the base or subtracted from it. The mode fields pick the indexing form: plain pre-indexed, pre-indexed with the sum written back to the base, or post-indexed, where the unmodified base goes to memory and the sum goes back to the base. A separate select makes the program counter the base, which gives PC-relative addressing.

The register file, the memory port and the instruction decoder sit outside the block. A request is presented together with `req_valid` and is captured at a rising clock edge. The results are registered and appear one cycle later, alongside a one-cycle `res_valid` pulse. A two-state machine tracks the result stage. In `ST_IDLE` no result is being presented. In `ST_DONE` a fresh result is on the outputs. Its transitions are: `ST_IDLE` to `ST_DONE` on a request, `ST_DONE` to `ST_DONE` on a back-to-back request, `ST_DONE` to `ST_IDLE` when no request arrives, and `ST_IDLE` to `ST_IDLE` with no request.

Top module: `lsu_agu`

## Requirements
- R1: During and after reset with no request, `res_valid` and `base_wr` are 0, and `eff_addr` and `new_base` are 0.
- R2: A request captured at a rising edge shows its results, with `res_valid` high, after that edge. `res_valid` and `base_wr` are high for exactly one cycle per request. Without a request, `res_valid` and `base_wr` are 0 and `eff_addr` and `new_base` keep their last values.
- R3: Pre-indexed form (`idx_mode` = 2'b00): `eff_addr` = base + offset, `new_base` = base, and `base_wr` = 0.
- R4: Pre-indexed with writeback (`idx_mode` = 2'b01): `eff_addr` = base + offset, `new_base` equals that same sum, and `base_wr` = 1.
- R5: Post-indexed form (`idx_mode` = 2'b10): `eff_addr` = base, `new_base` = base + offset, and `base_wr` = 1.
- R6: When `off_is_reg` = 0, the offset is `off_imm` read as a 12-bit two's-complement value and sign-extended to 32 bits.
- R7: When `off_is_reg` = 1, the offset is `off_reg` shifted logically by `shift_amt` (0 to 31): left when `shift_right` = 0, right when `shift_right` = 1. A shift amount of 0 passes `off_reg` through unchanged.
- R8: When `sub_off` = 1, the offset is subtracted from the base instead of added. It applies to either offset source, and all sums wrap modulo 2^32.
- R9: When `pc_rel` = 1, the base is `pc_in` + 8, the immediate offset is used, and the form is pre-indexed, whatever `idx_mode` and `off_is_reg` hold. `base_wr` = 0 and `new_base` = `base_in`.
- R10: `idx_mode` = 2'b11 behaves exactly like the pre-indexed form.
- R11: A stack push is pre-indexed with writeback, immediate -4 and `sub_off` = 0. Both `eff_addr` and `new_base` become the base minus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| base_in | input | 32 | Base register value |
| pc_in | input | 32 | Address of the current instruction |
| off_reg | input | 32 | Register offset before shifting |
| off_imm | input | 12 | Signed immediate offset |
| off_is_reg | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| shift_right | input | 1 | Shift direction for the register offset, 1 is logical right |
| shift_amt | input | 5 | Shift amount for the register offset |
| sub_off | input | 1 | 1 subtracts the offset from the base |
| idx_mode | input | 2 | 00 pre, 01 pre with writeback, 10 post, 11 as pre |
| pc_rel | input | 1 | Use the program counter plus 8 as base |
| res_valid | output | 1 | Results on the outputs belong to the request of the previous cycle |
| eff_addr | output | 32 | Effective address |
| new_base | output | 32 | Updated base register value |
| base_wr | output | 1 | Strobe: write `new_base` back to the base register |

## Verification
A fault inside the block shows at the ports within the one cycle after the request that exposes it. Take a stuck stage in the barrel shifter: only shift amounts that use that stage give a wrong `eff_addr` or `new_base`. The bench therefore mixes random shift amounts with the corner values 0 and 31. A wrong indexing decode shows up as a swapped `eff_addr`/`new_base` pair, or as a `base_wr` on the wrong request. A wrong state in the result stage shows up as a `res_valid` pulse that lasts longer than one cycle, or as outputs that move while the block is idle. The idle cycles between requests check that the outputs hold.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        IDX_PRE    = 2'b00,
        IDX_PRE_WB = 2'b01,
        IDX_POST   = 2'b10,
        IDX_RSVD   = 2'b11
    } idx_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } res_state_e;

endpackage

// File: rtl/agu_offset_shifter.sv
module agu_offset_shifter #(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           to_right,
    output logic [W-1:0]   dout
);

    logic [SHW:0][W-1:0] stage;

    assign stage[0] = din;

    genvar s;
    generate
        for (s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            logic [W-1:0] moved;
            always_comb begin
                if (to_right) moved = stage[s] >> DIST;
                else          moved = stage[s] << DIST;
            end
            assign stage[s+1] = amt[s] ? moved : stage[s];
        end
    endgenerate

    assign dout = stage[SHW];

endmodule

// File: rtl/agu_offset_select.sv
module agu_offset_select #(
    parameter int W    = 32,
    parameter int IMMW = 12
) (
    input  logic [IMMW-1:0] imm,
    input  logic [W-1:0]    reg_shifted,
    input  logic            use_reg,
    input  logic            negate,
    output logic [W-1:0]    offset
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] imm_ext;
    logic [W-1:0] picked;

    assign imm_ext = {{(W-IMMW){imm[IMMW-1]}}, imm};

    always_comb begin
        picked = use_reg ? reg_shifted : imm_ext;
        offset = negate ? (~picked + ONE) : picked;
    end

endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import agu_pkg::*;
#(
    parameter int W       = 32,
    parameter int IMMW    = 12,
    parameter int SHW     = 5,
    parameter int PC_BIAS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [W-1:0]    base_in,
    input  logic [W-1:0]    pc_in,
    input  logic [W-1:0]    off_reg,
    input  logic [IMMW-1:0] off_imm,
    input  logic            off_is_reg,
    input  logic            shift_right,
    input  logic [SHW-1:0]  shift_amt,
    input  logic            sub_off,
    input  logic [1:0]      idx_mode,
    input  logic            pc_rel,
    output logic            res_valid,
    output logic [W-1:0]    eff_addr,
    output logic [W-1:0]    new_base,
    output logic            base_wr
);

    localparam logic [W-1:0] PC_AHEAD = W'(PC_BIAS);

    res_state_e state_q, state_d;
    idx_mode_e  mode_eff;

    logic [W-1:0] off_shifted;
    logic [W-1:0] offset;
    logic [W-1:0] base_sel;
    logic [W-1:0] sum;
    logic [W-1:0] eff_d;
    logic [W-1:0] nb_d;
    logic         wr_d;
    logic         use_reg;

    logic [W-1:0] eff_q;
    logic [W-1:0] nb_q;
    logic         wr_q;

    agu_offset_shifter #(.W(W), .SHW(SHW)) u_shift (
        .din      (off_reg),
        .amt      (shift_amt),
        .to_right (shift_right),
        .dout     (off_shifted)
    );

    assign use_reg = off_is_reg & ~pc_rel;

    agu_offset_select #(.W(W), .IMMW(IMMW)) u_osel (
        .imm         (off_imm),
        .reg_shifted (off_shifted),
        .use_reg     (use_reg),
        .negate      (sub_off),
        .offset      (offset)
    );

    // Indexing decode: PC-relative forces plain pre-indexed.
    always_comb begin
        if (pc_rel) begin
            mode_eff = IDX_PRE;
            base_sel = pc_in + PC_AHEAD;
        end else begin
            mode_eff = idx_mode_e'(idx_mode);
            base_sel = base_in;
        end
        sum = base_sel + offset;
        unique case (mode_eff)
            IDX_PRE_WB: begin eff_d = sum;      nb_d = sum;     wr_d = 1'b1; end
            IDX_POST:   begin eff_d = base_sel; nb_d = sum;     wr_d = 1'b1; end
            IDX_PRE,
            IDX_RSVD:   begin eff_d = sum;      nb_d = base_in; wr_d = 1'b0; end
            default:    begin eff_d = sum;      nb_d = base_in; wr_d = 1'b0; end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_q <= '0;
            nb_q  <= '0;
            wr_q  <= 1'b0;
        end else if (req_valid) begin
            eff_q <= eff_d;
            nb_q  <= nb_d;
            wr_q  <= wr_d;
        end
    end

    // Outputs
    always_comb begin
        res_valid = (state_q == ST_DONE);
        base_wr   = (state_q == ST_DONE) && wr_q;
        eff_addr  = eff_q;
        new_base  = nb_q;
    end

    p_wr_with_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |-> res_valid);

    p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(eff_addr) && $stable(new_base)));

    p_pcrel_no_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pc_rel) |=> !base_wr);

    p_post_base_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pc_rel && idx_mode == 2'b10) |=> (eff_addr == $past(base_in) && base_wr));

    p_wb_same_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pc_rel && idx_mode == 2'b01) |=> (new_base == eff_addr && base_wr));

    p_pre_keeps_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (pc_rel || !idx_mode[0] && !idx_mode[1] || idx_mode == 2'b11))
            |=> (new_base == $past(base_in) && !base_wr));

    p_zero_shift_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_amt == '0) |-> (off_shifted == off_reg));

endmodule

// File: tb/tb_lsu_agu.sv
module tb_lsu_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_in = '0, pc_in = '0, off_reg = '0;
    logic [11:0] off_imm = '0;
    logic        off_is_reg = 1'b0, shift_right = 1'b0, sub_off = 1'b0, pc_rel = 1'b0;
    logic [4:0]  shift_amt = '0;
    logic [1:0]  idx_mode = '0;
    logic        res_valid, base_wr;
    logic [31:0] eff_addr, new_base;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] x_eff, x_nb;
    logic        x_wr;

    always #10 clk = ~clk;

    lsu_agu dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_in(base_in),
        .pc_in(pc_in), .off_reg(off_reg), .off_imm(off_imm), .off_is_reg(off_is_reg),
        .shift_right(shift_right), .shift_amt(shift_amt), .sub_off(sub_off),
        .idx_mode(idx_mode), .pc_rel(pc_rel), .res_valid(res_valid),
        .eff_addr(eff_addr), .new_base(new_base), .base_wr(base_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of R3-R10 from the requirement text
    task automatic model();
        logic [31:0] b, off, s;
        logic [1:0]  m;
        b = pc_rel ? pc_in + 32'd8 : base_in;
        if (off_is_reg && !pc_rel)
            off = shift_right ? (off_reg >> shift_amt) : (off_reg << shift_amt);
        else
            off = {{20{off_imm[11]}}, off_imm};
        s = sub_off ? b - off : b + off;
        m = pc_rel ? 2'b00 : idx_mode;
        case (m)
            2'b01:   begin x_eff = s; x_nb = s;       x_wr = 1'b1; end
            2'b10:   begin x_eff = b; x_nb = s;       x_wr = 1'b1; end
            default: begin x_eff = s; x_nb = base_in; x_wr = 1'b0; end
        endcase
    endtask

    task automatic issue(input string req);
        @(negedge clk);
        req_valid = 1'b1;
        model();
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, {31'd0, res_valid}, 32'd1);
        chk({req, " eff_addr"}, eff_addr, x_eff);
        chk({req, " new_base"}, new_base, x_nb);
        chk({req, " base_wr"}, {31'd0, base_wr}, {31'd0, x_wr});
    endtask

    task automatic set_req(input logic [31:0] b, input logic [31:0] pc, input logic [31:0] r,
                           input logic [11:0] im, input logic isr, input logic rt,
                           input logic [4:0] amt, input logic sb, input logic [1:0] md,
                           input logic pr);
        base_in = b; pc_in = pc; off_reg = r; off_imm = im; off_is_reg = isr;
        shift_right = rt; shift_amt = amt; sub_off = sb; idx_mode = md; pc_rel = pr;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_e, hold_n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 eff_addr", eff_addr, 32'd0);
        chk("R1 new_base", new_base, 32'd0);
        chk("R1 base_wr", {31'd0, base_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, res_valid}, 32'd0);

        // Directed corners
        set_req(32'h0000_2008, 0, 0, 12'hFFC, 0, 0, 0, 0, 2'b01, 0);
        issue("R11 push");
        set_req(32'h0000_1000, 32'h0000_1000, 32'hDEAD_BEEF, 12'd52, 1, 0, 3, 0, 2'b01, 1);
        issue("R9 pc relative");
        set_req(32'h0000_0500, 0, 32'h1234_5678, 12'd0, 1, 0, 0, 0, 2'b00, 0);
        issue("R7 zero shift R3");
        set_req(32'h0000_0000, 0, 32'h8000_0000, 12'd0, 1, 1, 31, 0, 2'b10, 0);
        issue("R7 right 31 R5");
        set_req(32'h0000_0100, 0, 32'h0000_0019, 12'd0, 1, 0, 2, 0, 2'b10, 0);
        issue("R5 post shifted");
        set_req(32'h0000_0010, 0, 0, 12'h800, 0, 0, 0, 0, 2'b00, 0);
        issue("R6 imm -2048");
        set_req(32'h0000_0003, 0, 32'h0000_0010, 12'd0, 1, 0, 0, 1, 2'b01, 0);
        issue("R8 subtract wrap R4");
        set_req(32'h0000_4000, 0, 0, 12'd100, 0, 0, 0, 1, 2'b11, 0);
        issue("R10 mode 11 R8");

        // R2: idle cycles hold outputs, no strobe
        hold_e = eff_addr; hold_n = new_base;
        @(negedge clk);
        chk("R2 idle valid", {31'd0, res_valid}, 32'd0);
        chk("R2 idle base_wr", {31'd0, base_wr}, 32'd0);
        chk("R2 idle eff hold", eff_addr, hold_e);
        chk("R2 idle base hold", new_base, hold_n);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            set_req($urandom, $urandom, $urandom, 12'($urandom), 1'($urandom), 1'($urandom),
                    5'($urandom), 1'($urandom), 2'($urandom), ($urandom % 6) == 0);
            issue("R3-R10 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule